// File: doc/BRIEF.md
# Power-Up Access Gate

This block is a host-side sequencer that sits in front of a serial flash controller. It decides when the controller may touch the flash after the supply comes up. A digital supply-valid input, sampled on the system clock, starts one elapsed-time measurement. Two thresholds are taken from that single measurement. Crossing the first threshold lets the controller drive chip select and issue reads. Crossing the second, later threshold also allows program and erase commands.

Requests that come in before their permission flag is set are not lost. Each request class has a one-entry hold stage. The stage keeps the request while permission is missing and releases it as a one-cycle issue strobe once permission is granted. If the supply-valid input drops at any time, both flags clear in that same cycle, any held requests are discarded, and measurement starts over from zero.

Both thresholds are given in nanoseconds. They are converted to whole clock cycles from a clock-frequency parameter, rounding up. The program/erase wait must be no shorter than the read wait.

Top module: `pwr_access_gate`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release with `supply_ok` low, the outputs `rd_ok`, `pe_ok`, `rd_issue`, `pe_issue` and `done` are all 0.
- R2: `rd_ok` is first high right after the RD_CYC-th consecutive rising edge that samples `supply_ok` high. It is low right after the edge before that one. RD_CYC = ceil(RD_WAIT_NS * CLK_HZ / 1e9), with a minimum of 1.
- R3: `pe_ok` follows the same rule with PE_CYC = ceil(PE_WAIT_NS * CLK_HZ / 1e9). Whenever `pe_ok` is high, `rd_ok` is high too.
- R4: In any cycle where `supply_ok` is low, `rd_ok` and `pe_ok` are both low in that same cycle with no clock delay. When `supply_ok` returns, both waits are measured again from zero.
- R5: Suppose a read request is sampled high at edge m, counted from the first edge that sees `supply_ok` high. Then `rd_issue` is high for exactly the one cycle after edge max(m, RD_CYC+1). A held request is released in the cycle after `rd_ok` rises.
- R6: A program/erase request sampled high at edge m gives a one-cycle `pe_issue` after edge max(m, PE_CYC+1).
- R7: A held request is discarded if `supply_ok` is sampled low. No issue strobe for it appears after the supply returns.
- R8: `done` is high for exactly one cycle, the cycle after `pe_ok` rises. It pulses once per supply-valid period.
- R9: While `supply_ok` stays high, both flags stay set indefinitely. The measurement saturates and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-valid indication, synchronous to clk |
| rd_req | input | 1 | Read request, sampled each edge |
| pe_req | input | 1 | Program/erase request, sampled each edge |
| rd_ok | output | 1 | Chip select and reads permitted |
| pe_ok | output | 1 | Program and erase permitted |
| rd_issue | output | 1 | One-cycle strobe: read may start now |
| pe_issue | output | 1 | One-cycle strobe: program/erase may start now |
| done | output | 1 | One-cycle pulse once both permissions hold |

## Verification
Edges are counted from the first edge that samples `supply_ok` high:
- `rd_ok` and `pe_ok` become visible right after edge RD_CYC and edge PE_CYC.
- An issue strobe follows edge max(m, limit+1) for a request sampled at edge m.
- `done` follows edge PE_CYC+1.
- Flag clearing is combinational and is seen within the same cycle as the supply drop.

The bench drives inputs and samples outputs 2 ns after each rising edge, so every observation belongs to a known edge number. It checks each result at its due edge and also at the edge before. For the combinational clear, it looks 1 ns after changing `supply_ok`, before any further edge.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

  // Whole clock cycles covering a wait of ns nanoseconds at hz, rounded up, never zero.
  function automatic longint unsigned wait_cycles(input longint unsigned ns,
                                                  input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c == 64'd0) ? 64'd1 : c;
  endfunction

  // Number of request classes handled by the hold stages: 0 = read, 1 = program/erase.
  localparam int unsigned NUM_CLASSES = 2;

endpackage

// File: rtl/pg_uptime_counter.sv
module pg_uptime_counter #(
  parameter int unsigned CNT_W = 8,
  parameter logic [CNT_W-1:0] RD_LIM = 1,
  parameter logic [CNT_W-1:0] PE_LIM = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic rd_ok,
  output logic pe_ok
);
  logic [CNT_W-1:0] up_cnt;

  // Count edges that see the supply valid; saturate at the longer limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              up_cnt <= '0;
    else if (!supply_ok)     up_cnt <= '0;
    else if (up_cnt != PE_LIM) up_cnt <= up_cnt + CNT_W'(1);
  end

  // Gated by supply_ok so that a drop clears permission without a clock delay.
  assign rd_ok = supply_ok && (up_cnt >= RD_LIM);
  assign pe_ok = supply_ok && (up_cnt >= PE_LIM);
endmodule

// File: rtl/pg_req_hold.sv
module pg_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic grant,
  input  logic req,
  output logic issue,
  output logic pending
);
  logic want;
  assign want = pending || req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue   <= 1'b0;
      pending <= 1'b0;
    end else begin
      issue   <= grant && want;
      pending <= supply_ok && !grant && want;
    end
  end
endmodule

// File: rtl/pg_once_pulse.sv
module pg_once_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      seen  <= level;
      pulse <= level && !seen;
    end
  end
endmodule

// File: rtl/pwr_access_gate.sv
module pwr_access_gate
  import pwr_gate_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 64'd125_000_000,
  parameter longint unsigned RD_WAIT_NS = 64'd85_000,
  parameter longint unsigned PE_WAIT_NS = 64'd3_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic rd_req,
  input  logic pe_req,
  output logic rd_ok,
  output logic pe_ok,
  output logic rd_issue,
  output logic pe_issue,
  output logic done
);
  localparam longint unsigned RD_CYC = wait_cycles(RD_WAIT_NS, CLK_HZ);
  localparam longint unsigned PE_CYC = wait_cycles(PE_WAIT_NS, CLK_HZ);
  localparam int unsigned     CNT_W  = $clog2(PE_CYC + 64'd1);
  localparam logic [CNT_W-1:0] RD_LIM = CNT_W'(RD_CYC);
  localparam logic [CNT_W-1:0] PE_LIM = CNT_W'(PE_CYC);

  // Named internal events, observed by the bound checker.
  logic [NUM_CLASSES-1:0] grant_v;
  logic [NUM_CLASSES-1:0] req_v;
  logic [NUM_CLASSES-1:0] issue_v;
  logic [NUM_CLASSES-1:0] pend_v;

  pg_uptime_counter #(
    .CNT_W (CNT_W),
    .RD_LIM(RD_LIM),
    .PE_LIM(PE_LIM)
  ) u_uptime (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .rd_ok    (rd_ok),
    .pe_ok    (pe_ok)
  );

  assign grant_v = {pe_ok, rd_ok};
  assign req_v   = {pe_req, rd_req};

  for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_hold
    pg_req_hold u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .supply_ok(supply_ok),
      .grant    (grant_v[i]),
      .req      (req_v[i]),
      .issue    (issue_v[i]),
      .pending  (pend_v[i])
    );
  end

  assign rd_issue = issue_v[0];
  assign pe_issue = issue_v[1];

  pg_once_pulse u_done (
    .clk  (clk),
    .rst_n(rst_n),
    .level(pe_ok),
    .pulse(done)
  );
endmodule

// File: rtl/pwr_access_gate_chk.sv
module pwr_access_gate_chk
  import pwr_gate_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 64'd125_000_000,
  parameter longint unsigned RD_WAIT_NS = 64'd85_000,
  parameter longint unsigned PE_WAIT_NS = 64'd3_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       rd_ok,
  input logic       pe_ok,
  input logic       rd_issue,
  input logic       pe_issue,
  input logic       done,
  input logic [1:0] pend_v
);
  localparam longint unsigned RD_CYC = wait_cycles(RD_WAIT_NS, CLK_HZ);
  localparam longint unsigned PE_CYC = wait_cycles(PE_WAIT_NS, CLK_HZ);

  // Independent run-length of sampled supply-valid edges.
  longint unsigned hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hi_run <= 64'd0;
    else if (!supply_ok)            hi_run <= 64'd0;
    else if (hi_run < PE_CYC + 64'd2) hi_run <= hi_run + 64'd1;
  end

  // R2
  rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_ok) |-> hi_run == RD_CYC);
  // R3
  pe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pe_ok) |-> hi_run == PE_CYC);
  // R3
  pe_implies_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_ok |-> rd_ok);
  // R4
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (!rd_ok && !pe_ok));
  // R5
  rd_issue_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |-> $past(rd_ok));
  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v[0] && rd_ok) |=> rd_issue);
  // R6
  pe_issue_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_issue |-> $past(pe_ok));
  // R6
  pe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v[1] && pe_ok) |=> pe_issue);
  // R7
  drop_discards_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (pend_v == 2'b00));
  // R8
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(pe_ok) && !$past(pe_ok, 2)));
endmodule

bind pwr_access_gate pwr_access_gate_chk #(
  .CLK_HZ    (CLK_HZ),
  .RD_WAIT_NS(RD_WAIT_NS),
  .PE_WAIT_NS(PE_WAIT_NS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .supply_ok(supply_ok),
  .rd_ok    (rd_ok),
  .pe_ok    (pe_ok),
  .rd_issue (rd_issue),
  .pe_issue (pe_issue),
  .done     (done),
  .pend_v   (pend_v)
);

// File: tb/test_pwr_access_gate.sv
module test_pwr_access_gate;
  localparam int RD_NS = 203;
  localparam int PE_NS = 1001;
  // 125 MHz: cycles = ceil(ns * 125 / 1000)
  localparam int RD_E = (RD_NS * 125 + 999) / 1000;  // 26
  localparam int PE_E = (PE_NS * 125 + 999) / 1000;  // 126

  localparam int NV = 8;
  // kind: 0 = read, 1 = program/erase; request edge; expected issue edge
  localparam int VK [NV] = '{0, 0, 0, 0, 1, 1, 1, 1};
  localparam int VM [NV] = '{3, RD_E, RD_E + 1, RD_E + 9, 1, RD_E + 4, PE_E + 1, PE_E + 4};
  localparam int VE [NV] = '{RD_E + 1, RD_E + 1, RD_E + 1, RD_E + 9,
                             PE_E + 1, PE_E + 1, PE_E + 1, PE_E + 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic rd_req = 1'b0;
  logic pe_req = 1'b0;
  logic rd_ok, pe_ok, rd_issue, pe_issue, done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwr_access_gate #(
    .CLK_HZ    (64'd125_000_000),
    .RD_WAIT_NS(64'(RD_NS)),
    .PE_WAIT_NS(64'(PE_NS))
  ) i_pwr_access_gate (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .rd_req(rd_req), .pe_req(pe_req),
    .rd_ok(rd_ok), .pe_ok(pe_ok), .rd_issue(rd_issue), .pe_issue(pe_issue), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // Supply low for two edges, then high; the next edge is edge 1.
  task automatic power_cycle();
    supply_ok = 1'b0;
    tick();
    tick();
    supply_ok = 1'b1;
  endtask

  task automatic run_req(input int kind, input int m, output int first, output int cnt);
    power_cycle();
    first = -1;
    cnt = 0;
    for (int e = 1; e <= PE_E + 6; e++) begin
      rd_req = (kind == 0) && (e == m);
      pe_req = (kind == 1) && (e == m);
      tick();
      if ((kind == 0) ? rd_issue : pe_issue) begin
        cnt++;
        if (first < 0) first = e;
      end
    end
    rd_req = 1'b0;
    pe_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int first, cnt, dones;
    // R1: reset state, even with supply valid during reset
    supply_ok = 1'b1;
    tick(); tick(); tick();
    chk("R1 flags in reset", int'({rd_ok, pe_ok}), 0);
    chk("R1 strobes in reset", int'({rd_issue, pe_issue, done}), 0);
    supply_ok = 1'b0;
    rst_n = 1'b1;
    tick();
    chk("R1 outputs after release", int'({rd_ok, pe_ok, rd_issue, pe_issue, done}), 0);

    // R5 R6: table of request timings
    for (int v = 0; v < NV; v++) begin
      run_req(VK[v], VM[v], first, cnt);
      chk((VK[v] == 0) ? "R5 read issue edge" : "R6 pe issue edge", first, VE[v]);
      chk((VK[v] == 0) ? "R5 read issue count" : "R6 pe issue count", cnt, 1);
    end

    // R2 R3 R8 R9: flag timing, done pulse, saturation
    power_cycle();
    dones = 0;
    for (int e = 1; e <= PE_E + 200; e++) begin
      tick();
      if (done) dones++;
      if (e == RD_E - 1) chk("R2 rd_ok before limit", int'(rd_ok), 0);
      if (e == RD_E) begin
        chk("R2 rd_ok at limit", int'(rd_ok), 1);
        chk("R3 pe_ok still low", int'(pe_ok), 0);
      end
      if (e == PE_E - 1) chk("R3 pe_ok before limit", int'(pe_ok), 0);
      if (e == PE_E) begin
        chk("R3 pe_ok at limit", int'(pe_ok), 1);
        chk("R8 done not yet", int'(done), 0);
      end
      if (e == PE_E + 1) chk("R8 done after rise", int'(done), 1);
    end
    chk("R8 single done pulse", dones, 1);
    chk("R9 flags held", int'({rd_ok, pe_ok}), 3);

    // R4: drop clears at once, then timing restarts from zero
    supply_ok = 1'b0;
    #1;
    chk("R4 same-cycle clear", int'({rd_ok, pe_ok}), 0);
    tick();
    supply_ok = 1'b1;
    for (int e = 1; e <= RD_E; e++) begin
      tick();
      if (e == RD_E - 1) chk("R4 restart rd_ok low", int'(rd_ok), 0);
      if (e == RD_E) chk("R4 restart rd_ok high", int'(rd_ok), 1);
    end

    // R7: held program/erase request dropped by a supply drop
    power_cycle();
    for (int e = 1; e <= 20; e++) begin
      pe_req = (e == 5);
      tick();
    end
    pe_req = 1'b0;
    supply_ok = 1'b0;
    tick(); tick();
    supply_ok = 1'b1;
    cnt = 0;
    for (int e = 1; e <= PE_E + 10; e++) begin
      tick();
      if (pe_issue) cnt++;
    end
    chk("R7 pe_ok reached", int'(pe_ok), 1);
    chk("R7 discarded request", cnt, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule